// File: doc/BRIEF.md
# Debug Exception Trap Filter

This block sits between the exception logic of a CPU and its debug unit. Every exception the core raises is offered to the filter as a class code with a one-cycle valid strobe. The filter looks up the class in a host-programmed enable mask. An enabled class is trapped: the core is told at once to drop the exception, a sticky per-class reason flag is set, and the core is held in a debug stall. A class that is not enabled passes through untouched, and it also releases any stall that is in force.

The exception event is a plain strobe with no ready signal. The filter accepts an event on every cycle that the strobe is high and never pushes back. The exception vectoring itself lives elsewhere. A host reaches the filter through two write ports and two readback outputs. The enable mask is written whole. The reason flags are cleared by writing zeros to the flags to be dropped. A mode input can keep the stall from reaching the core while trapped classes are still logged.

Top module: `debug_trap_filter`

## Requirements
- R1: After reset, the enable mask, the reason flags, `cpu_stall` and `exc_ignore` are all zero.
- R2: A cycle with `stop_we` high loads `stop_wdata` into the enable mask, and `stop_q` shows it after that clock edge.
- R3: Class codes are 0 reset, 1 bus error, 2 data page fault, 3 instruction page fault, 4 tick timer, 5 alignment, 6 illegal instruction, 7 external interrupt, 8 data TLB miss, 9 instruction TLB miss, 10 range, 11 system call, 12 trap. Mask bit k enables class k. `exc_ignore` is high in the same cycle as `exc_valid` exactly when the mask bit of `exc_code` is set.
- R4: A trapped event sets reason bit `exc_code` at the next edge, and all other reason bits are kept.
- R5: A trapped event with `dbg_disable` low raises `cpu_stall` from the next cycle on. The stall holds until a later event that is not trapped.
- R6: A valid event that is not trapped leaves the reason flags unchanged, keeps `exc_ignore` low, and drives `cpu_stall` low from the next cycle.
- R7: Codes 13 to 15 are never trapped, whatever the mask holds.
- R8: While `dbg_disable` is high, `cpu_stall` is low and a trap does not arm the stall. The reason bit is still recorded and `exc_ignore` still asserts.
- R9: A cycle with `reason_we` high replaces the flags with `reason_q & reason_wdata`. A trap in the same cycle still sets its own bit.
- R10: Cycles with `exc_valid` low change neither the stall nor the reason flags.
- R11: An event in the same cycle as a mask write is judged against the mask value held before that write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset of the debug unit |
| exc_valid | input | 1 | Exception event strobe, one cycle per event |
| exc_code | input | 4 | Exception class code |
| dbg_disable | input | 1 | Keeps the stall from reaching the core |
| stop_we | input | 1 | Enable-mask write strobe |
| stop_wdata | input | 13 | New enable mask |
| reason_we | input | 1 | Reason-flag clear strobe |
| reason_wdata | input | 13 | Keep mask, where a zero bit clears that flag |
| exc_ignore | output | 1 | Core must drop the current exception |
| cpu_stall | output | 1 | Debug stall request to the core |
| stop_q | output | 13 | Current enable mask |
| reason_q | output | 13 | Sticky reason flags |

## Verification
The bench checks that a class whose mask bit is clear releases a stall that is already held. A design that only ever sets the stall would keep the core frozen. It sends codes 13 to 15, which a decoder that wraps or truncates the code would wrongly map onto a real class. It lines up a reason clear with a trap of the same class in one cycle, which catches a write path that overrides the new flag. It also lines up a mask write with an event, which catches a filter that judges against the freshly written mask. Finally, it raises the disable mode while a stall is held and during a trap. A design that gates the log along with the stall would lose the reason bit.

// File: rtl/dtf_pkg.sv
package dtf_pkg;
  localparam int NUM_CLASSES = 13;
  localparam int CODE_W      = 4;

  typedef enum logic [CODE_W-1:0] {
    EXC_RESET   = 4'd0,
    EXC_BUSERR  = 4'd1,
    EXC_DPAGE   = 4'd2,
    EXC_IPAGE   = 4'd3,
    EXC_TICK    = 4'd4,
    EXC_ALIGN   = 4'd5,
    EXC_ILLEGAL = 4'd6,
    EXC_EXTINT  = 4'd7,
    EXC_DTLB    = 4'd8,
    EXC_ITLB    = 4'd9,
    EXC_RANGE   = 4'd10,
    EXC_SYSCALL = 4'd11,
    EXC_TRAP    = 4'd12
  } exc_class_e;
endpackage

// File: rtl/dtf_decode.sv
module dtf_decode #(
  parameter int N = 13,
  parameter int W = 4
) (
  input  logic         valid,
  input  logic [W-1:0] code,
  output logic [N-1:0] hot
);
  // Codes at or above N match no lane, so they can never trap.
  for (genvar i = 0; i < N; i++) begin : g_lane
    assign hot[i] = valid && (code == W'(i));
  end
endmodule

// File: rtl/dtf_regs.sv
module dtf_regs #(
  parameter int N = 13
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         stop_we,
  input  logic [N-1:0] stop_wdata,
  input  logic         reason_we,
  input  logic [N-1:0] reason_wdata,
  input  logic [N-1:0] set_vec,
  output logic [N-1:0] stop_q,
  output logic [N-1:0] reason_q
);
  logic [N-1:0] reason_kept;

  // The host clear acts first; a trap in the same cycle still lands.
  assign reason_kept = reason_we ? (reason_q & reason_wdata) : reason_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stop_q   <= '0;
      reason_q <= '0;
    end else begin
      if (stop_we) stop_q <= stop_wdata;
      reason_q <= reason_kept | set_vec;
    end
  end
endmodule

// File: rtl/dtf_stall.sv
module dtf_stall (
  input  logic clk,
  input  logic rst_n,
  input  logic event_valid,
  input  logic trapped,
  input  logic dbg_disable,
  output logic stall
);
  logic stall_q;

  always_ff @(posedge clk) begin
    if (!rst_n) stall_q <= 1'b0;
    else if (event_valid) stall_q <= trapped && !dbg_disable;
  end

  assign stall = stall_q && !dbg_disable;
endmodule

// File: rtl/debug_trap_filter.sv
module debug_trap_filter
  import dtf_pkg::*;
#(
  parameter int NUM_CLASSES = dtf_pkg::NUM_CLASSES,
  parameter int CODE_W      = dtf_pkg::CODE_W
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   exc_valid,
  input  logic [CODE_W-1:0]      exc_code,
  input  logic                   dbg_disable,
  input  logic                   stop_we,
  input  logic [NUM_CLASSES-1:0] stop_wdata,
  input  logic                   reason_we,
  input  logic [NUM_CLASSES-1:0] reason_wdata,
  output logic                   exc_ignore,
  output logic                   cpu_stall,
  output logic [NUM_CLASSES-1:0] stop_q,
  output logic [NUM_CLASSES-1:0] reason_q
);
  logic [NUM_CLASSES-1:0] class_hot;
  logic [NUM_CLASSES-1:0] trap_vec;

  dtf_decode #(.N(NUM_CLASSES), .W(CODE_W)) u_decode (
    .valid (exc_valid),
    .code  (exc_code),
    .hot   (class_hot)
  );

  // Decision uses the mask as held before any write in this cycle.
  assign trap_vec   = class_hot & stop_q;
  assign exc_ignore = |trap_vec;

  dtf_regs #(.N(NUM_CLASSES)) u_regs (
    .clk          (clk),
    .rst_n        (rst_n),
    .stop_we      (stop_we),
    .stop_wdata   (stop_wdata),
    .reason_we    (reason_we),
    .reason_wdata (reason_wdata),
    .set_vec      (trap_vec),
    .stop_q       (stop_q),
    .reason_q     (reason_q)
  );

  dtf_stall u_stall (
    .clk         (clk),
    .rst_n       (rst_n),
    .event_valid (exc_valid),
    .trapped     (exc_ignore),
    .dbg_disable (dbg_disable),
    .stall       (cpu_stall)
  );
endmodule

// File: rtl/debug_trap_filter_chk.sv
module debug_trap_filter_chk #(
  parameter int NUM_CLASSES = 13,
  parameter int CODE_W      = 4
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   exc_valid,
  input logic [CODE_W-1:0]      exc_code,
  input logic                   dbg_disable,
  input logic                   reason_we,
  input logic                   exc_ignore,
  input logic                   cpu_stall,
  input logic [NUM_CLASSES-1:0] reason_q
);
  logic [NUM_CLASSES-1:0] code_bit;
  assign code_bit = NUM_CLASSES'(1) << exc_code;

  // R3
  ignore_needs_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    exc_ignore |-> exc_valid);

  // R7
  out_of_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (exc_valid && (int'(exc_code) >= NUM_CLASSES)) |-> !exc_ignore);

  // R4
  trap_records_chk: assert property (@(posedge clk) disable iff (!rst_n)
    exc_ignore |=> |(reason_q & $past(code_bit)));

  // R9
  reason_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !reason_we |=> ((reason_q & $past(reason_q)) == $past(reason_q)));

  // R8
  disable_blocks_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dbg_disable |-> !cpu_stall);

  // R6
  pass_releases_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (exc_valid && !exc_ignore) |=> !cpu_stall);

  // R5
  trap_stalls_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (exc_ignore && !dbg_disable) |=> (cpu_stall || dbg_disable));
endmodule

bind debug_trap_filter debug_trap_filter_chk #(
  .NUM_CLASSES (NUM_CLASSES),
  .CODE_W      (CODE_W)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .exc_valid   (exc_valid),
  .exc_code    (exc_code),
  .dbg_disable (dbg_disable),
  .reason_we   (reason_we),
  .exc_ignore  (exc_ignore),
  .cpu_stall   (cpu_stall),
  .reason_q    (reason_q)
);

// File: tb/debug_trap_filter_tb.sv
module debug_trap_filter_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        exc_valid = 1'b0;
  logic [3:0]  exc_code = '0;
  logic        dbg_disable = 1'b0;
  logic        stop_we = 1'b0;
  logic [12:0] stop_wdata = '0;
  logic        reason_we = 1'b0;
  logic [12:0] reason_wdata = '0;
  logic        exc_ignore, cpu_stall;
  logic [12:0] stop_q, reason_q;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  debug_trap_filter u_dut (
    .clk(clk), .rst_n(rst_n), .exc_valid(exc_valid), .exc_code(exc_code),
    .dbg_disable(dbg_disable), .stop_we(stop_we), .stop_wdata(stop_wdata),
    .reason_we(reason_we), .reason_wdata(reason_wdata),
    .exc_ignore(exc_ignore), .cpu_stall(cpu_stall),
    .stop_q(stop_q), .reason_q(reason_q)
  );

  // {code, disable, exp_ignore, exp_stall_after, exp_reason_after}
  localparam logic [19:0] VECS [8] = '{
    {4'd2,  1'b0, 1'b1, 1'b1, 13'h004},
    {4'd3,  1'b0, 1'b0, 1'b0, 13'h004},
    {4'd9,  1'b0, 1'b1, 1'b1, 13'h204},
    {4'd14, 1'b0, 1'b0, 1'b0, 13'h204},
    {4'd11, 1'b1, 1'b1, 1'b0, 13'hA04},
    {4'd0,  1'b0, 1'b1, 1'b1, 13'hA05},
    {4'd12, 1'b0, 1'b0, 1'b0, 13'hA05},
    {4'd6,  1'b0, 1'b1, 1'b1, 13'hA45}
  };

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic fire(input logic [3:0] code, input logic dis);
    @(negedge clk);
    exc_valid = 1'b1; exc_code = code; dbg_disable = dis;
    #1;
  endtask

  task automatic idle();
    @(negedge clk);
    exc_valid = 1'b0; stop_we = 1'b0; reason_we = 1'b0;
    #1;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    #1;
    // R1: reset state
    chk("R1", "stop", 32'(stop_q), 0);
    chk("R1", "reason", 32'(reason_q), 0);
    chk("R1", "stall", 32'(cpu_stall), 0);
    chk("R1", "ignore", 32'(exc_ignore), 0);
    @(negedge clk); rst_n = 1'b1;

    // R2: program the enable mask
    @(negedge clk); stop_we = 1'b1; stop_wdata = 13'h0A55;
    idle();
    chk("R2", "stop", 32'(stop_q), 32'h0A55);

    // Table walk: R3 R4 R5 R6 R7 R8
    for (int i = 0; i < 8; i++) begin
      fire(VECS[i][19:16], VECS[i][15]);
      chk("R3", $sformatf("ignore vec%0d", i), 32'(exc_ignore), 32'(VECS[i][14]));
      idle();
      chk("R5/R6/R8", $sformatf("stall vec%0d", i), 32'(cpu_stall), 32'(VECS[i][13]));
      chk("R4/R6/R7", $sformatf("reason vec%0d", i), 32'(reason_q), 32'(VECS[i][12:0]));
    end

    // R10: idle cycles keep stall and flags
    repeat (3) idle();
    chk("R10", "stall held", 32'(cpu_stall), 1);
    chk("R10", "reason held", 32'(reason_q), 32'hA45);

    // R8: disable drops a held stall at once
    @(negedge clk); dbg_disable = 1'b1; #1;
    chk("R8", "stall masked", 32'(cpu_stall), 0);
    @(negedge clk); dbg_disable = 1'b0; #1;
    chk("R8", "stall back", 32'(cpu_stall), 1);

    // R9: host clears bit 2
    @(negedge clk); reason_we = 1'b1; reason_wdata = ~13'h004;
    idle();
    chk("R9", "clear", 32'(reason_q), 32'hA41);

    // R9: clear of bit 0 with trap of class 0 in one cycle
    fire(4'd0, 1'b0);
    reason_we = 1'b1; reason_wdata = 13'h1FFE;
    idle();
    chk("R9", "trap beats clear", 32'(reason_q), 32'hA41);

    // R11: mask write together with an event
    fire(4'd2, 1'b0);
    stop_we = 1'b1; stop_wdata = 13'h0000;
    chk("R11", "old mask used", 32'(exc_ignore), 1);
    idle();
    chk("R11", "mask now", 32'(stop_q), 0);
    chk("R11", "reason", 32'(reason_q), 32'hA45);
    fire(4'd2, 1'b0);
    chk("R11", "new mask used", 32'(exc_ignore), 0);
    idle();
    chk("R6", "stall released", 32'(cpu_stall), 0);

    // R7: codes 13..15 with full mask
    @(negedge clk); stop_we = 1'b1; stop_wdata = 13'h1FFF;
    idle();
    for (int c = 13; c < 16; c++) begin
      fire(4'(c), 1'b0);
      chk("R7", $sformatf("code %0d", c), 32'(exc_ignore), 0);
      idle();
      chk("R7", $sformatf("reason code %0d", c), 32'(reason_q), 32'hA45);
    end

    // R1: reset mid-run clears everything
    @(negedge clk); rst_n = 1'b0;
    idle();
    chk("R1", "reason after reset", 32'(reason_q), 0);
    chk("R1", "stop after reset", 32'(stop_q), 0);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #2000000;
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule